// File: doc/BRIEF.md
# SECDED Error Event Logger

This block sits next to a SECDED-protected RAM and keeps a record of the error events that the RAM read path reports. The read path does the check-bit computation, the detection and the correction. It gives this block two kinds of one-cycle pulse, each with the failing byte address:

- corrected (single-bit) events;
- uncorrectable (double-bit) events.

Turning logging on or off has no effect on the checking in the read path.

Corrected events are counted against a programmable threshold. When the count reaches the threshold, the block sets a status flag and captures the failing word address. It raises an interrupt if that interrupt is enabled, and it restarts the count. Uncorrectable events bypass the counter. They set their own flag, capture their own address and drive a separate output flag.

A control bit is brought out so that software can open the RAM's check-bit array to direct writes and inject faults. Software reaches all state through a small 32-bit register port, which returns read data one cycle after the read.

Top module: `ecc_err_logger`

Register map (byte offsets): 0x00 control, 0x04 threshold, 0x08 count (read-only), 0x0C status, 0x10 corrected-event address (read-only), 0x14 uncorrectable-event address (read-only), 0x18 interrupt enable.

## Requirements
- R1: After reset every register reads 0, and `sbe_irq`, `ube_flag` and `chk_wr_open` are 0.
- R2: While control bit 0 (logging enable) is 0, error pulses change no count, flag or captured address.
- R3: With logging enabled and a non-zero threshold, each corrected pulse adds one to the count at offset 0x08 while the result stays below the threshold.
- R4: The corrected pulse that brings the count to the threshold does three things: it sets status bit 0, it captures the address, and it returns the count to 0. With a threshold of 1, the first pulse sets the flag and leaves the count reading 0.
- R5: Uncorrectable pulses never change the count. Instead they set status bit 1, capture the address at offset 0x14, and drive `ube_flag` high.
- R6: A captured address keeps only byte-address bits 17:3, in the same bit positions. All other bits read as 0.
- R7: While a status flag is set, its captured address holds. Writing 1 to that status bit clears the flag, and writing 0 to it leaves the flag unchanged. The next qualifying event after the clear captures afresh.
- R8: A threshold of 0 stops the counting and keeps `sbe_irq` low.
- R9: `sbe_irq` is high exactly when status bit 0 is set, bit 0 at offset 0x18 is 1 and the threshold is non-zero.
- R10: `chk_wr_open` follows control bit 8. Clearing the bit closes the check-bit array again.
- R11: Read data appears in the cycle after `reg_rd` and is 0 in any other cycle. Unmapped offsets and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_pulse | input | 1 | Corrected-error event, one cycle |
| sbe_addr | input | ADDR_W | Byte address of the corrected event |
| ube_pulse | input | 1 | Uncorrectable-error event, one cycle |
| ube_addr | input | ADDR_W | Byte address of the uncorrectable event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| sbe_irq | output | 1 | Corrected-error interrupt |
| ube_flag | output | 1 | Uncorrectable-error flag |
| chk_wr_open | output | 1 | Opens the check-bit array to direct writes |

## Verification
All state changes from an event pulse or a register write take effect at the clock edge that samples them. As a result, `sbe_irq`, `ube_flag` and `chk_wr_open` are correct one edge after the stimulus. Register contents are correct one further edge after a read strobe.

The bench drives stimulus on falling edges. For a read, it queues the expected word when it raises `reg_rd`. A monitor sees the strobe at the rising edge and compares `reg_rdata` on the following falling edge. Pin outputs are compared on the falling edge after the stimulus edge.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   // word indices of the register map (byte offset / 4)
   localparam int WIX_CTRL  = 0;
   localparam int WIX_THR   = 1;
   localparam int WIX_CNT   = 2;
   localparam int WIX_STAT  = 3;
   localparam int WIX_SADDR = 4;
   localparam int WIX_UADDR = 5;
   localparam int WIX_IEN   = 6;
   // field positions
   localparam int CTRL_LOG_BIT  = 0;
   localparam int CTRL_OPEN_BIT = 8;
   localparam int STAT_SBE_BIT  = 0;
   localparam int STAT_UBE_BIT  = 1;
   localparam int IEN_SBE_BIT   = 0;
endpackage

// File: rtl/ecc_log_occ_counter.sv
module ecc_log_occ_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             evt,
   input  logic [CNT_W-1:0] thr,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W:0] nxt;

   always_comb begin
      nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
      // greater-or-equal so a lowered threshold still terminates the run
      hit = en && evt && (nxt >= {1'b0, thr});
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (en && evt)
         cnt <= hit ? '0 : nxt[CNT_W-1:0];
   end
endmodule

// File: rtl/ecc_log_addr_latch.sv
module ecc_log_addr_latch #(
   parameter int ADDR_W     = 32,
   parameter int CAP_HI     = 17,
   parameter int CAP_LO     = 3,
   parameter bit KEEP_FIRST = 1'b1,
   localparam int CAP_W     = CAP_HI - CAP_LO + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   output logic              flag,
   output logic [CAP_W-1:0]  cap
);
   logic load;

   generate
      if (KEEP_FIRST) begin : g_first
         assign load = set && (!flag || clr);
      end else begin : g_last
         assign load = set;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         cap  <= '0;
      end else begin
         if (set)      flag <= 1'b1;
         else if (clr) flag <= 1'b0;
         if (load)     cap  <= addr[CAP_HI:CAP_LO];
      end
   end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CAP_HI = 17,
   parameter int CAP_LO = 3,
   parameter int CNT_W  = 16,
   parameter int REG_AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sbe_pulse,
   input  logic [ADDR_W-1:0] sbe_addr,
   input  logic              ube_pulse,
   input  logic [ADDR_W-1:0] ube_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              sbe_irq,
   output logic              ube_flag,
   output logic              chk_wr_open
);
   localparam int CAP_W  = CAP_HI - CAP_LO + 1;
   localparam int WIX_W  = REG_AW - 2;

   generate
      if (CNT_W < 1 || CNT_W > 32)     begin : g_bad_cnt  $error("CNT_W out of range"); end
      if (CAP_LO > CAP_HI)             begin : g_bad_cap  $error("capture range reversed"); end
      if (CAP_HI >= ADDR_W || CAP_HI > 31) begin : g_bad_hi $error("capture range too wide"); end
      if (REG_AW < 5)                  begin : g_bad_raw  $error("REG_AW too small for map"); end
   endgenerate

   logic [WIX_W-1:0] widx;
   logic             log_en, open_q, ien_q;
   logic [CNT_W-1:0] thr_q, cnt_q;
   logic             thr_nz, sbe_hit;
   logic             sflag, uflag, sclr, uclr;
   logic [CAP_W-1:0] saddr_q, uaddr_q;
   logic [31:0]      rd_mux;

   assign widx   = reg_addr[REG_AW-1:2];
   assign thr_nz = (thr_q != '0);

   // control, threshold and enable registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_en <= 1'b0;
         open_q <= 1'b0;
         thr_q  <= '0;
         ien_q  <= 1'b0;
      end else if (reg_wr) begin
         if (widx == WIX_W'(WIX_CTRL)) begin
            log_en <= reg_wdata[CTRL_LOG_BIT];
            open_q <= reg_wdata[CTRL_OPEN_BIT];
         end
         if (widx == WIX_W'(WIX_THR)) thr_q <= reg_wdata[CNT_W-1:0];
         if (widx == WIX_W'(WIX_IEN)) ien_q <= reg_wdata[IEN_SBE_BIT];
      end
   end

   assign sclr = reg_wr && (widx == WIX_W'(WIX_STAT)) && reg_wdata[STAT_SBE_BIT];
   assign uclr = reg_wr && (widx == WIX_W'(WIX_STAT)) && reg_wdata[STAT_UBE_BIT];

   ecc_log_occ_counter #(.CNT_W(CNT_W)) u_occ (
      .clk(clk), .rst_n(rst_n),
      .en(log_en && thr_nz), .evt(sbe_pulse), .thr(thr_q),
      .cnt(cnt_q), .hit(sbe_hit)
   );

   ecc_log_addr_latch #(.ADDR_W(ADDR_W), .CAP_HI(CAP_HI), .CAP_LO(CAP_LO), .KEEP_FIRST(1'b1)) u_sbe_lat (
      .clk(clk), .rst_n(rst_n), .set(sbe_hit), .clr(sclr),
      .addr(sbe_addr), .flag(sflag), .cap(saddr_q)
   );

   ecc_log_addr_latch #(.ADDR_W(ADDR_W), .CAP_HI(CAP_HI), .CAP_LO(CAP_LO), .KEEP_FIRST(1'b1)) u_ube_lat (
      .clk(clk), .rst_n(rst_n), .set(log_en && ube_pulse), .clr(uclr),
      .addr(ube_addr), .flag(uflag), .cap(uaddr_q)
   );

   assign sbe_irq     = sflag && ien_q && thr_nz;
   assign ube_flag    = uflag;
   assign chk_wr_open = open_q;

   // read mux, registered for one-cycle latency
   always_comb begin
      rd_mux = '0;
      case (widx)
         WIX_W'(WIX_CTRL): begin
            rd_mux[CTRL_LOG_BIT]  = log_en;
            rd_mux[CTRL_OPEN_BIT] = open_q;
         end
         WIX_W'(WIX_THR):   rd_mux[CNT_W-1:0] = thr_q;
         WIX_W'(WIX_CNT):   rd_mux[CNT_W-1:0] = cnt_q;
         WIX_W'(WIX_STAT): begin
            rd_mux[STAT_SBE_BIT] = sflag;
            rd_mux[STAT_UBE_BIT] = uflag;
         end
         WIX_W'(WIX_SADDR): rd_mux[CAP_HI:CAP_LO] = saddr_q;
         WIX_W'(WIX_UADDR): rd_mux[CAP_HI:CAP_LO] = uaddr_q;
         WIX_W'(WIX_IEN):   rd_mux[IEN_SBE_BIT] = ien_q;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
      else             reg_rdata <= '0;
   end
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
   import ecc_log_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int CAP_W  = 15,
   parameter int REG_AW = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sbe_pulse,
   input logic              ube_pulse,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              chk_wr_open,
   input logic              log_en,
   input logic [CNT_W-1:0]  thr_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              sflag,
   input logic              uflag,
   input logic [CAP_W-1:0]  saddr_q
);
   localparam int WIX_W = REG_AW - 2;
   logic [WIX_W-1:0] widx;
   assign widx = reg_addr[REG_AW-1:2];

   assert_log_off_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!log_en && !reg_wr) |=> ($stable(cnt_q) && $stable(sflag) && $stable(uflag)));

   assert_hit_resets_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (log_en && sbe_pulse && thr_q != '0 && ({1'b0, cnt_q} + 1'b1 >= {1'b0, thr_q}))
      |=> (cnt_q == '0 && sflag));

   assert_ube_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ube_pulse && !sbe_pulse) |=> $stable(cnt_q));

   assert_saddr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sflag && !(reg_wr && widx == WIX_W'(WIX_STAT) && reg_wdata[STAT_SBE_BIT]))
      |=> $stable(saddr_q));

   assert_open_follows_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && widx == WIX_W'(WIX_CTRL)) |=> (chk_wr_open == $past(reg_wdata[CTRL_OPEN_BIT])));

   assert_idle_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));
endmodule

bind ecc_err_logger ecc_err_logger_chk #(
   .CNT_W(CNT_W), .CAP_W(CAP_HI - CAP_LO + 1), .REG_AW(REG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sbe_pulse(sbe_pulse), .ube_pulse(ube_pulse),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .chk_wr_open(chk_wr_open), .log_en(log_en),
   .thr_q(thr_q), .cnt_q(cnt_q), .sflag(sflag), .uflag(uflag), .saddr_q(saddr_q)
);

// File: tb/ecc_err_logger_tb_top.sv
`timescale 1ns/1ps
module ecc_err_logger_tb_top;
   localparam logic [5:0] A_CTRL = 6'h00, A_THR = 6'h04, A_CNT = 6'h08, A_STAT = 6'h0C,
                          A_SADDR = 6'h10, A_UADDR = 6'h14, A_IEN = 6'h18;
   localparam logic [31:0] CAP_MASK = 32'h0003_FFF8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sbe_pulse = 1'b0, ube_pulse = 1'b0;
   logic [31:0] sbe_addr = '0, ube_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sbe_irq, ube_flag, chk_wr_open;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   ecc_err_logger dut_i (
      .clk(clk), .rst_n(rst_n), .sbe_pulse(sbe_pulse), .sbe_addr(sbe_addr),
      .ube_pulse(ube_pulse), .ube_addr(ube_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sbe_irq(sbe_irq), .ube_flag(ube_flag), .chk_wr_open(chk_wr_open)
   );

   task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   // driver: issue read, push expected value for the monitor
   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      q_exp.push_back(exp); q_tag.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic sbe(input logic [31:0] a);
      @(negedge clk);
      sbe_pulse = 1'b1; sbe_addr = a;
      @(negedge clk);
      sbe_pulse = 1'b0;
   endtask

   task automatic ube(input logic [31:0] a);
      @(negedge clk);
      ube_pulse = 1'b1; ube_addr = a;
      @(negedge clk);
      ube_pulse = 1'b0;
   endtask

   // monitor: data due at the falling edge after the strobe-sampling edge
   initial begin
      forever begin
         @(posedge clk);
         if (reg_rd) begin
            @(negedge clk);
            if (q_exp.size() == 0) compare("R11 unexpected read", reg_rdata, 32'hX);
            else compare(q_tag.pop_front(), reg_rdata, q_exp.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      compare("R1 sbe_irq", {31'b0, sbe_irq}, 32'd0);
      compare("R1 ube_flag", {31'b0, ube_flag}, 32'd0);
      compare("R1 chk_wr_open", {31'b0, chk_wr_open}, 32'd0);
      rd(A_CTRL, 0, "R1 ctrl");   rd(A_THR, 0, "R1 thr");
      rd(A_CNT, 0, "R1 cnt");     rd(A_STAT, 0, "R1 stat");
      rd(A_SADDR, 0, "R1 saddr"); rd(A_UADDR, 0, "R1 uaddr");
      rd(A_IEN, 0, "R1 ien");

      // R10 check-bit write gate
      wr(A_CTRL, 32'h100);
      compare("R10 open", {31'b0, chk_wr_open}, 32'd1);
      rd(A_CTRL, 32'h100, "R10 ctrl readback");
      wr(A_CTRL, 32'h0);
      compare("R10 closed", {31'b0, chk_wr_open}, 32'd0);

      // R2 logging disabled
      wr(A_THR, 3);
      wr(A_IEN, 1);
      sbe(32'h0000_1000); ube(32'h0000_2000);
      rd(A_CNT, 0, "R2 cnt");
      rd(A_STAT, 0, "R2 stat");
      compare("R2 ube_flag", {31'b0, ube_flag}, 32'd0);

      // R3 counting, R4/R6/R9 threshold hit
      wr(A_CTRL, 32'h1);
      sbe(32'h0000_0040);
      sbe(32'h0000_0080);
      rd(A_CNT, 2, "R3 cnt after two");
      compare("R9 irq low before hit", {31'b0, sbe_irq}, 32'd0);
      sbe(32'hFFFF_FFFF);
      compare("R9 irq high", {31'b0, sbe_irq}, 32'd1);
      rd(A_CNT, 0, "R4 cnt cleared");
      rd(A_STAT, 1, "R4 stat");
      rd(A_SADDR, CAP_MASK, "R6 saddr masked");

      // R7 hold while set, clear with write-1
      sbe(32'h100); sbe(32'h100); sbe(32'h100);
      rd(A_SADDR, CAP_MASK, "R7 saddr held");
      wr(A_STAT, 32'h0);
      rd(A_STAT, 1, "R7 write0 keeps");
      wr(A_STAT, 32'h1);
      rd(A_STAT, 0, "R7 cleared");
      compare("R9 irq after clear", {31'b0, sbe_irq}, 32'd0);

      // R4 threshold 1, R6 address with captured bits zero, R9 disabled irq
      wr(A_IEN, 0);
      wr(A_THR, 1);
      sbe(32'h0800_0000);
      rd(A_STAT, 1, "R4 thr1 stat");
      rd(A_CNT, 0, "R4 thr1 cnt");
      rd(A_SADDR, 0, "R6 saddr zero bits");
      compare("R9 irq gated by enable", {31'b0, sbe_irq}, 32'd0);

      // R5 uncorrectable path
      wr(A_STAT, 32'h1);
      wr(A_THR, 2);
      sbe(32'h0000_0200);
      rd(A_CNT, 1, "R3 cnt one");
      ube(32'hABC1_2345);
      compare("R5 ube_flag", {31'b0, ube_flag}, 32'd1);
      rd(A_CNT, 1, "R5 cnt unchanged");
      rd(A_STAT, 2, "R5 stat");
      rd(A_UADDR, 32'hABC1_2345 & CAP_MASK, "R5 uaddr");
      wr(A_STAT, 32'h2);
      compare("R7 ube cleared", {31'b0, ube_flag}, 32'd0);

      // R8 threshold zero
      wr(A_IEN, 1);
      wr(A_THR, 0);
      sbe(32'h8); sbe(32'h8); sbe(32'h8);
      rd(A_CNT, 1, "R8 cnt frozen");
      rd(A_STAT, 0, "R8 stat");
      compare("R8 irq", {31'b0, sbe_irq}, 32'd0);

      // R11 unmapped offsets
      rd(6'h1C, 0, "R11 unmapped 0x1C");
      rd(6'h3C, 0, "R11 unmapped 0x3C");
      @(negedge clk);
      compare("R11 idle rdata", reg_rdata, 32'd0);

      repeat (4) @(negedge clk);
      compare("R11 queue drained", q_exp.size(), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule